// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This unit rearranges the elements of a vector register under a per-element mask, one element per clock cycle. In compress mode it gathers the source elements whose mask bit is set and writes them into consecutive destination slots, starting at slot 0, keeping their original order. In expand mode it does the reverse: it takes source elements 0, 1, 2 and so on, and writes each one to the next destination position whose mask bit is set.

The vector register file stays outside the unit. The unit drives a source element index and receives that element's data in the same cycle. It drives a destination index, data and write enable, and it never writes a destination element that the operation does not select. Software or a sequencer starts an operation with the mode, the mask and the active length. It receives a one-cycle completion pulse and the packed length, which is the number of active mask bits. That count becomes the vector length for the operations that follow.

Top module: `vmce_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `dst_we` are 0 and `pack_len` is 0.
- R2: Compress (`mode` = 0): for each set mask bit at index i < vl, in ascending i, the unit writes source element i into destination slot k, where k counts the earlier set bits. It makes at most one write per cycle.
- R3: When `done` is high, and until the next accepted start, `pack_len` equals the number of set mask bits below vl. It also equals the number of destination writes made by that operation.
- R4: In compress, destination slots at index `pack_len` or above are never written.
- R5: Expand (`mode` = 1): the k-th set mask bit, counted from 0 in ascending index i < vl, causes source element k to be written to destination position i.
- R6: In expand, destination positions whose mask bit is 0 are not written and keep their previous contents.
- R7: Mask bits at indices at or above vl have no effect. A vl above VLMAX is treated as VLMAX.
- R8: An all-zero mask gives `pack_len` = 0 and makes no destination writes, in either mode.
- R9: A start sampled at clock edge E is accepted when idle. Element i is handled in the cycle after edge E+i. `done` is high for exactly one cycle, following edge E+vl, so vl = 0 gives `done` right after E.
- R10: `start` is ignored while `busy` is high. Mode, mask and vl are captured only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 1 | 0 = compress, 1 = expand |
| mask | input | VLMAX | Per-element activity bits, bit i for element i |
| vl | input | LW | Active vector length |
| src_idx | output | IW | Source element index being read |
| src_data | input | EW | Source element data for `src_idx`, same cycle |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | IW | Destination element index |
| dst_data | output | EW | Destination write data |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| pack_len | output | LW | Number of active mask bits below vl |

## Verification
Two events can land in the same cycle: the write of the last element and the final step of the element counter, which moves the unit into its done state. The bench provokes this by setting the mask bit at index vl-1, in both modes and with a full 64-element vector. It then checks that the scoreboard receives that last write, that `done` appears exactly one cycle later, and that the count of writes matches `pack_len`. The bench also holds `start` high with a changed mask for a whole run, to check that a request arriving mid-operation cannot disturb the sequence in progress.

// File: rtl/vmce_pkg.sv
package vmce_pkg;

    typedef enum logic {
        VM_COMPRESS = 1'b0,
        VM_EXPAND   = 1'b1
    } vm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vm_state_e;

    // per-cycle control produced by the sequencer, consumed by the router
    typedef struct packed {
        logic     run;
        logic     act;
        vm_mode_e mode;
    } vm_step_t;

endpackage

// File: rtl/vmce_seq.sv
module vmce_seq
    import vmce_pkg::*;
#(
    parameter int VLMAX = 64,
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  vm_mode_e         mode,
    input  logic [VLMAX-1:0] mask,
    input  logic [LW-1:0]    vl,
    output logic             accept,
    output vm_step_t         step,
    output logic [IW-1:0]    e_idx,
    output logic [LW-1:0]    p_cnt,
    output vm_mode_e         mode_r,
    output logic             busy,
    output logic             done
);

    vm_state_e        state;
    logic [VLMAX-1:0] mask_r;
    logic [LW-1:0]    vl_r;
    logic [LW-1:0]    e_cnt;
    logic             act;
    logic             last;

    assign accept = (state == ST_IDLE) && start;
    assign act    = mask_r[e_cnt[IW-1:0]];
    assign last   = (e_cnt == vl_r - LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_r <= VM_COMPRESS;
            mask_r <= '0;
            vl_r   <= '0;
            e_cnt  <= '0;
            p_cnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_r <= mode;
                        mask_r <= mask;
                        vl_r   <= vl;
                        e_cnt  <= '0;
                        p_cnt  <= '0;
                        state  <= (vl == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    e_cnt <= e_cnt + LW'(1);
                    if (act) begin
                        p_cnt <= p_cnt + LW'(1);
                    end
                    if (last) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign step.run  = (state == ST_RUN);
    assign step.act  = act;
    assign step.mode = mode_r;
    assign e_idx     = e_cnt[IW-1:0];
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/vmce_route.sv
module vmce_route
    import vmce_pkg::*;
#(
    parameter int VLMAX = 64,
    parameter int EW    = 32,
    localparam int IW = $clog2(VLMAX)
) (
    input  vm_step_t      step,
    input  logic [IW-1:0] e_idx,
    input  logic [IW-1:0] p_idx,
    input  logic [EW-1:0] src_data,
    output logic [IW-1:0] src_idx,
    output logic          dst_we,
    output logic [IW-1:0] dst_idx,
    output logic [EW-1:0] dst_data
);

    // compress reads sparse and writes dense; expand swaps the two indices
    always_comb begin
        if (step.mode == VM_EXPAND) begin
            src_idx = p_idx;
            dst_idx = e_idx;
        end else begin
            src_idx = e_idx;
            dst_idx = p_idx;
        end
        dst_we   = step.run && step.act;
        dst_data = src_data;
    end

endmodule

// File: rtl/vmce_len.sv
module vmce_len #(
    parameter int VLMAX = 64,
    localparam int LW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [VLMAX-1:0] mask,
    input  logic [LW-1:0]    vl,
    output logic [LW-1:0]    pack_len
);

    logic [LW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < VLMAX; i++) begin
            if ((LW'(i) < vl) && mask[i]) begin
                ones = ones + LW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pack_len <= '0;
        end else if (accept) begin
            pack_len <= ones;
        end
    end

endmodule

// File: rtl/vmce_unit.sv
module vmce_unit
    import vmce_pkg::*;
#(
    parameter int VLMAX = 64,
    parameter int EW    = 32,
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic [VLMAX-1:0] mask,
    input  logic [LW-1:0]    vl,
    output logic [IW-1:0]    src_idx,
    input  logic [EW-1:0]    src_data,
    output logic             dst_we,
    output logic [IW-1:0]    dst_idx,
    output logic [EW-1:0]    dst_data,
    output logic             busy,
    output logic             done,
    output logic [LW-1:0]    pack_len
);

    logic          accept;
    vm_step_t      step;
    logic [IW-1:0] e_idx;
    logic [LW-1:0] p_cnt;
    vm_mode_e      mode_r;
    logic [LW-1:0] vl_eff;

    assign vl_eff = (vl > LW'(VLMAX)) ? LW'(VLMAX) : vl;

    vmce_seq #(.VLMAX(VLMAX)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .mode   (vm_mode_e'(mode)),
        .mask   (mask),
        .vl     (vl_eff),
        .accept (accept),
        .step   (step),
        .e_idx  (e_idx),
        .p_cnt  (p_cnt),
        .mode_r (mode_r),
        .busy   (busy),
        .done   (done)
    );

    vmce_route #(.VLMAX(VLMAX), .EW(EW)) u_route (
        .step     (step),
        .e_idx    (e_idx),
        .p_idx    (p_cnt[IW-1:0]),
        .src_data (src_data),
        .src_idx  (src_idx),
        .dst_we   (dst_we),
        .dst_idx  (dst_idx),
        .dst_data (dst_data)
    );

    vmce_len #(.VLMAX(VLMAX)) u_len (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .mask     (mask),
        .vl       (vl_eff),
        .pack_len (pack_len)
    );

endmodule

// File: rtl/vmce_chk.sv
module vmce_chk
    import vmce_pkg::*;
#(
    parameter int VLMAX = 64,
    localparam int IW = $clog2(VLMAX),
    localparam int LW = $clog2(VLMAX + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          dst_we,
    input logic [IW-1:0] dst_idx,
    input logic [IW-1:0] src_idx,
    input vm_mode_e      mode_r,
    input logic [LW-1:0] pack_len,
    input logic [LW-1:0] p_cnt
);

    logic [LW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) begin
            wcnt <= '0;
        end else if (dst_we) begin
            wcnt <= wcnt + LW'(1);
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R6
    we_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> (busy && !done));

    // R4
    cmp_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_we && mode_r == VM_COMPRESS) |-> (LW'(dst_idx) < pack_len));

    // R5
    exp_src_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_we && mode_r == VM_EXPAND) |-> (LW'(src_idx) < pack_len));

    // R3
    wcount_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (wcnt == pack_len && p_cnt == pack_len));

    // R3
    len_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pack_len));

endmodule

bind vmce_unit vmce_chk #(.VLMAX(VLMAX)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .dst_we   (dst_we),
    .dst_idx  (dst_idx),
    .src_idx  (src_idx),
    .mode_r   (mode_r),
    .pack_len (pack_len),
    .p_cnt    (p_cnt)
);

// File: tb/sim_vmce_unit.sv
`timescale 1ns/1ps
module sim_vmce_unit;

    localparam int N  = 64;
    localparam int EW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          mode;
    logic [N-1:0]  mask;
    logic [6:0]    vl;
    logic [5:0]    src_idx;
    logic [EW-1:0] src_data;
    logic          dst_we;
    logic [5:0]    dst_idx;
    logic [EW-1:0] dst_data;
    logic          busy;
    logic          done;
    logic [6:0]    pack_len;

    logic [EW-1:0] smem  [N];
    logic [EW-1:0] dmem  [N];
    logic [EW-1:0] emem  [N];
    int            q_idx [$];
    logic [EW-1:0] q_dat [$];
    int            checks = 0;
    int            fails  = 0;
    int            cycles = 0;
    string         cur_tag = "R2";

    always #2.5 clk = ~clk;

    assign src_data = smem[src_idx];

    vmce_unit u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .mask(mask), .vl(vl),
        .src_idx(src_idx), .src_data(src_data), .dst_we(dst_we), .dst_idx(dst_idx),
        .dst_data(dst_data), .busy(busy), .done(done), .pack_len(pack_len)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every write must match the next expected item
    always @(negedge clk) begin
        if (!rst && dst_we) begin
            dmem[dst_idx] = dst_data;
            checks++;
            if (q_idx.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected write idx %0d data %0h, expected none",
                         cur_tag, dst_idx, dst_data);
            end else begin
                int ei;
                logic [EW-1:0] ed;
                ei = q_idx.pop_front();
                ed = q_dat.pop_front();
                if (int'(dst_idx) != ei || dst_data !== ed) begin
                    fails++;
                    $display("FAIL %s: write idx %0d data %0h, expected idx %0d data %0h",
                             cur_tag, dst_idx, dst_data, ei, ed);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run(input bit md, input logic [N-1:0] m, input int vlen,
                       input bit hold, input string tag, input int seed);
        int vle;
        int pc;
        int k;
        int bad;
        cur_tag = tag;
        vle = (vlen > N) ? N : vlen;
        for (int i = 0; i < N; i++) begin
            smem[i] = 32'h5000_0000 + i * 3 + seed * 256;
            dmem[i] = 32'hD000_0000 + i + seed * 256;
            emem[i] = dmem[i];
        end
        pc = 0;
        for (int i = 0; i < vle; i++) begin
            if (m[i]) begin
                if (!md) begin
                    q_idx.push_back(pc);
                    q_dat.push_back(smem[i]);
                    emem[pc] = smem[i];
                end else begin
                    q_idx.push_back(i);
                    q_dat.push_back(smem[pc]);
                    emem[i] = smem[pc];
                end
                pc++;
            end
        end
        @(negedge clk);
        start = 1'b1;
        mode  = md;
        mask  = m;
        vl    = 7'(vlen);
        k = 0;
        forever begin
            @(negedge clk);
            if (hold) begin
                mask = ~m;
                mode = ~md;
            end else begin
                start = 1'b0;
            end
            if (done) break;
            k++;
            if (k > 200) break;
        end
        start = 1'b0;
        // R9: done follows the last element's edge
        check(k == vle, {tag, " R9 done cycle"}, k, vle);
        // R3: packed length
        check(int'(pack_len) == pc, {tag, " R3 pack_len"}, pack_len, pc);
        check(q_idx.size() == 0, {tag, " missing writes"}, q_idx.size(), 0);
        bad = 0;
        for (int i = 0; i < N; i++) if (dmem[i] !== emem[i]) bad++;
        // R4 / R6: elements outside the selection are untouched
        check(bad == 0, {tag, " R4 R6 destination contents"}, bad, 0);
        @(negedge clk);
        check(!done && !busy, {tag, " R9 single done pulse"}, {done, busy}, 0);
        check(int'(pack_len) == pc, {tag, " R3 pack_len held"}, pack_len, pc);
        q_idx.delete();
        q_dat.delete();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode = 1'b0; mask = '0; vl = '0;
        for (int i = 0; i < N; i++) begin smem[i] = '0; dmem[i] = '0; emem[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        check(!busy && !done && !dst_we && pack_len == 0, "R1 reset state",
              {busy, done, dst_we}, 0);
        run(1'b0, 64'hB2, 8, 1'b0, "R2 compress sparse", 1);
        run(1'b1, 64'hB2, 8, 1'b0, "R5 expand sparse", 2);
        run(1'b0, '1, 64, 1'b0, "R2 compress full", 3);
        run(1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 64, 1'b0, "R5 R6 expand alternating", 4);
        run(1'b0, 64'h8000_0000_0000_0001, 64, 1'b0, "R4 compress ends", 5);
        run(1'b0, '0, 40, 1'b0, "R8 compress zero mask", 6);
        run(1'b1, '0, 40, 1'b0, "R8 expand zero mask", 7);
        run(1'b0, '1, 10, 1'b0, "R7 mask beyond vl", 8);
        run(1'b1, 64'hF0F0_0000_0000_0F0F, 100, 1'b0, "R7 vl clamp", 9);
        run(1'b0, 64'h5, 0, 1'b0, "R9 zero length", 10);
        run(1'b0, 64'h0000_0000_0000_C3A5, 16, 1'b1, "R10 start held", 11);
        run(1'b1, 64'h0000_0000_0000_0001, 1, 1'b0, "R9 single element", 12);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule